// File: doc/BRIEF.md
# Four-Axis Joystick Position Timer

This block times how long each of up to four joystick axis comparators takes to switch after a measurement begins. The result is a 16-bit count per axis that is proportional to the axis position. Software enables the axes it cares about and writes any value to the axis-value address to start a one-shot measurement. Each enabled axis then counts prescaled clock ticks until its comparator input goes high. When every enabled axis has finished, the counts are latched, a ready flag is set and, if enabled, an interrupt is raised.

Software reads one latched count at a time. A two-bit select field in the configuration register picks the axis. A read strobe on the axis-value address returns the count and acknowledges the ready flag and the interrupt. A hardware-config register enables the interrupt and picks the count rate: the full clock, one half, one twentieth or one two-hundredth. In continuous mode the block starts a new measurement by itself a fixed number of cycles after each completion, so the latched counts keep updating. The analog charge circuit lies outside the block. The comparators arrive as synchronous digital inputs, and a per-axis charge output shows which axes are still being timed.

Top module: `gameport_axis_unit`

## Requirements
- R1: After reset, the configuration register, hardware-config register, all latched counts, the ready flag, irq and chargeOut are zero.
- R2: Configuration bit k (k = 0..3) enables axis k. A disabled axis never drives its chargeOut bit and its latched count is 0 after a measurement.
- R3: Register map on addr: 0 is configuration, 1 is axis value, 2 is hardware config, 3 reads 0. Configuration bits 5:4 select the axis read at address 1: 00 axis 0, 01 axis 1, 10 axis 2, 11 axis 3.
- R4: A write to address 1 starts a measurement. An enabled axis whose comparator stays low for K clock edges after the write edge, and is high from then on, latches floor(K/D), where D is the prescale divisor.
- R5: Hardware-config bits 2:1 set D: 00 gives 1, 10 gives 2, 01 gives 20, 11 gives 200.
- R6: An axis whose comparator never goes high stops at and latches 0xFFFF.
- R7: Configuration bit 7 is a read-only ready flag. It is set when every enabled axis has finished, cleared by a new start, and writes to it have no effect.
- R8: irq is raised with the ready flag only when hardware-config bit 0 is 1.
- R9: A read strobe (rdEn) at address 1 clears the ready flag and irq on the next edge.
- R10: With configuration bit 6 set, a new measurement starts RESTART_GAP cycles after each completion, setting ready (and irq) again.
- R11: Hardware-config bits 7:4 always read as zero; bits 3:0 read back as written.
- R12: chargeOut bit k is high for an enabled axis from the start edge until that axis finishes, and all chargeOut bits are low once ready is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (acknowledge side effect) |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 16 | Read data for addr, combinational |
| compIn | input | 4 | Per-axis comparator inputs, high when the axis timing ends |
| chargeOut | output | 4 | Per-axis timing-active indication |
| irq | output | 1 | Measurement-complete interrupt |

## Verification
The assertions check on every cycle that irq never stands without ready, that a clearing read drops both flags, that ready only rises on a completion, that no axis is charging once ready rises, and that the hardware-config upper nibble reads zero. Only the bench scenarios can show the count values themselves: floor(K/D) under each prescale code, saturation at 0xFFFF, zero counts on disabled axes, the select mapping, and the timed continuous restart.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_AXIS = 2'd1;
  localparam logic [1:0] ADDR_HW   = 2'd2;

  typedef struct packed {
    logic start;  // clear counters, begin timing
    logic tick;   // prescaled count enable
    logic latch;  // measurement finished, capture counts
    logic run;    // measurement in progress
  } gpStrobes_t;

  function automatic logic [7:0] rateDivisor(input logic [1:0] code);
    case (code)
      2'b00:   return 8'd1;
      2'b10:   return 8'd2;
      2'b01:   return 8'd20;
      default: return 8'd200;
    endcase
  endfunction
endpackage

// File: rtl/gp_ctrl.sv
module gp_ctrl
  import gp_pkg::*;
#(
  parameter int NUM_AXES    = 4,
  parameter int SEL_W       = 2,
  parameter int RESTART_GAP = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [1:0]          addr,
  input  logic [7:0]          wrData,
  input  logic                allDone,
  output gpStrobes_t          strb,
  output logic [NUM_AXES-1:0] axisEn,
  output logic [SEL_W-1:0]    axisSel,
  output logic                contMode,
  output logic [3:0]          hwCfg,
  output logic                ready,
  output logic                irqPend
);
  localparam int GAP_W = $clog2(RESTART_GAP + 1);

  logic             measuring;
  logic [7:0]       divCnt;
  logic [7:0]       divisor;
  logic             autoArm;
  logic [GAP_W-1:0] gapCnt;
  logic             trigger, autoFire, finish, rdAxis, tick;

  assign divisor  = rateDivisor(hwCfg[2:1]);
  assign trigger  = wrEn && (addr == ADDR_AXIS);
  assign rdAxis   = rdEn && (addr == ADDR_AXIS);
  assign autoFire = autoArm && (gapCnt == GAP_W'(RESTART_GAP - 1));
  assign tick     = measuring && (divCnt == divisor - 8'd1);
  assign finish   = measuring && allDone && !(trigger || autoFire);

  assign strb.start = trigger || autoFire;
  assign strb.tick  = tick;
  assign strb.latch = finish;
  assign strb.run   = measuring;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      axisEn   <= '0;
      axisSel  <= '0;
      contMode <= 1'b0;
      hwCfg    <= '0;
    end else if (wrEn && addr == ADDR_CFG) begin
      axisEn   <= wrData[NUM_AXES-1:0];
      axisSel  <= wrData[4 +: SEL_W];
      contMode <= wrData[6];
    end else if (wrEn && addr == ADDR_HW) begin
      hwCfg <= wrData[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      measuring <= 1'b0;
      divCnt    <= '0;
      ready     <= 1'b0;
      irqPend   <= 1'b0;
      autoArm   <= 1'b0;
      gapCnt    <= '0;
    end else begin
      if (strb.start) begin
        measuring <= 1'b1;
        divCnt    <= '0;
        ready     <= 1'b0;
        irqPend   <= 1'b0;
      end else if (finish) begin
        measuring <= 1'b0;
        ready     <= 1'b1;
        irqPend   <= hwCfg[0];
      end else begin
        if (measuring) divCnt <= tick ? '0 : divCnt + 8'd1;
        if (rdAxis) begin
          ready   <= 1'b0;
          irqPend <= 1'b0;
        end
      end

      if (strb.start || !contMode) autoArm <= 1'b0;
      else if (finish)             autoArm <= 1'b1;

      if (autoArm && !strb.start) gapCnt <= gapCnt + 1'b1;
      else                        gapCnt <= '0;
    end
  end
endmodule

// File: rtl/gp_axis_dp.sv
module gp_axis_dp
  import gp_pkg::*;
#(
  parameter int NUM_AXES = 4,
  parameter int SEL_W    = 2,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  gpStrobes_t          strb,
  input  logic [NUM_AXES-1:0] axisEn,
  input  logic [NUM_AXES-1:0] compIn,
  input  logic [SEL_W-1:0]    axisSel,
  output logic                allDone,
  output logic [NUM_AXES-1:0] chargeOut,
  output logic [CNT_W-1:0]    selResult
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]    cnt    [NUM_AXES];
  logic [CNT_W-1:0]    result [NUM_AXES];
  logic [NUM_AXES-1:0] doneReg;
  logic [NUM_AXES-1:0] doneNow;

  for (genvar i = 0; i < NUM_AXES; i++) begin : g_axis
    assign doneNow[i]   = doneReg[i] || compIn[i] || (cnt[i] == CNT_MAX);
    assign chargeOut[i] = strb.run && axisEn[i] && !doneReg[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt[i]     <= '0;
        result[i]  <= '0;
        doneReg[i] <= 1'b0;
      end else begin
        if (strb.start) begin
          cnt[i]     <= '0;
          doneReg[i] <= 1'b0;
        end else if (strb.run && axisEn[i] && !doneReg[i]) begin
          if (doneNow[i])     doneReg[i] <= 1'b1;
          else if (strb.tick) cnt[i]     <= cnt[i] + 1'b1;
        end
        if (strb.latch) result[i] <= cnt[i];
      end
    end
  end

  assign allDone   = &(doneNow | ~axisEn);
  assign selResult = result[axisSel];
endmodule

// File: rtl/gameport_axis_unit.sv
module gameport_axis_unit
  import gp_pkg::*;
#(
  parameter int NUM_AXES    = 4,
  parameter int CNT_W       = 16,
  parameter int RESTART_GAP = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [1:0]          addr,
  input  logic [7:0]          wrData,
  output logic [15:0]         rdData,
  input  logic [NUM_AXES-1:0] compIn,
  output logic [NUM_AXES-1:0] chargeOut,
  output logic                irq
);
  localparam int SEL_W = $clog2(NUM_AXES);

  gpStrobes_t          strb;
  logic [NUM_AXES-1:0] axisEn;
  logic [SEL_W-1:0]    axisSel;
  logic                contMode, readyFlag, irqPend, allDone, finishStrobe;
  logic [3:0]          hwCfg;
  logic [CNT_W-1:0]    selResult;

  gp_ctrl #(.NUM_AXES(NUM_AXES), .SEL_W(SEL_W), .RESTART_GAP(RESTART_GAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .allDone(allDone), .strb(strb), .axisEn(axisEn), .axisSel(axisSel),
    .contMode(contMode), .hwCfg(hwCfg), .ready(readyFlag), .irqPend(irqPend)
  );

  gp_axis_dp #(.NUM_AXES(NUM_AXES), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .axisEn(axisEn), .compIn(compIn),
    .axisSel(axisSel), .allDone(allDone), .chargeOut(chargeOut), .selResult(selResult)
  );

  assign irq          = irqPend;
  assign finishStrobe = strb.latch;

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CFG:  rdData[7:0] = 8'({readyFlag, contMode, 2'(axisSel), 4'(axisEn)});
      ADDR_AXIS: rdData      = 16'(selResult);
      ADDR_HW:   rdData[3:0] = hwCfg;
      default:   rdData      = '0;
    endcase
  end
endmodule

// File: rtl/gp_checker.sv
module gp_checker #(
  parameter int NUM_AXES = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                rdEn,
  input logic [1:0]          addr,
  input logic [15:0]         rdData,
  input logic                irq,
  input logic                ready,
  input logic                finish,
  input logic [NUM_AXES-1:0] chargeOut
);
  // R8: an interrupt only ever stands together with the ready flag
  a_r8_irq_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ready);

  // R11: hardware-config upper nibble reads zero
  a_r11_hw_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd2) |-> (rdData[15:4] == 12'd0));

  // R9: a clearing read drops ready and irq unless a completion coincides
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 2'd1 && !finish) |=> (!ready && !irq));

  // R7: ready rises only on a completion
  a_r7_ready_from_finish: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(finish));

  // R12: no axis is still charging when ready rises
  a_r12_idle_at_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> (chargeOut == '0));
endmodule

bind gameport_axis_unit gp_checker #(.NUM_AXES(NUM_AXES)) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .addr(addr), .rdData(rdData), .irq(irq),
  .ready(readyFlag), .finish(finishStrobe), .chargeOut(chargeOut)
);

// File: tb/tb_gameport_axis_unit.sv
module tb_gameport_axis_unit;
  localparam int GAP = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wrData = 8'd0;
  logic [15:0] rdData;
  logic [3:0]  compIn = 4'd0;
  logic [3:0]  chargeOut;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gameport_axis_unit #(.NUM_AXES(4), .CNT_W(16), .RESTART_GAP(GAP)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .compIn(compIn), .chargeOut(chargeOut), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int divOf(input logic [1:0] code);
    case (code)
      2'b00: return 1;
      2'b10: return 2;
      2'b01: return 20;
      default: return 200;
    endcase
  endfunction

  function automatic int expCount(input int k, input int d);
    int q = k / d;
    return (q > 65535) ? 65535 : q;
  endfunction

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic clearRead();
    @(negedge clk);
    rdEn = 1'b1; addr = 2'd1;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // one full measurement with comparator delays k[] and prescale code rc
  task automatic measure(input logic [3:0] en, input int k0, input int k1,
                         input int k2, input int k3, input logic [1:0] rc,
                         input bit irqOn);
    int kk[4];
    int d, maxK, lim;
    logic [15:0] v;
    kk[0] = k0; kk[1] = k1; kk[2] = k2; kk[3] = k3;
    d = divOf(rc);
    regWrite(2'd2, {5'd0, rc, irqOn});
    regWrite(2'd0, {4'd0, en});
    maxK = 0;
    for (int i = 0; i < 4; i++) if (en[i] && kk[i] > maxK) maxK = kk[i];
    lim = (maxK > 65535 * d) ? 65535 * d : maxK;
    @(negedge clk);
    compIn = 4'd0; wrEn = 1'b1; addr = 2'd1; wrData = 8'd0;
    @(posedge clk);
    for (int n = 0; n <= lim + d + 3; n++) begin
      @(negedge clk);
      wrEn = 1'b0;
      for (int i = 0; i < 4; i++) compIn[i] = (n >= kk[i]);
      if (n == 0) check(chargeOut == en, "R12/R2 chargeOut at start", chargeOut, en);
      @(posedge clk);
    end
    peek(2'd0, v);
    check(v[7] == 1'b1, "R7 ready after completion", v[7], 1);
    check(irq == irqOn, "R8 irq follows enable", irq, irqOn);
    check(chargeOut == 4'd0, "R12 chargeOut idle", chargeOut, 0);
    for (int i = 0; i < 4; i++) begin
      int e = en[i] ? expCount(kk[i], d) : 0;
      regWrite(2'd0, {2'b00, 2'(i), en});
      peek(2'd1, v);
      check(v == 16'(e), en[i] ? "R4/R5/R3 axis count" : "R2 disabled axis zero", v, e);
    end
    clearRead();
    peek(2'd0, v);
    check(v[7] == 1'b0 && irq == 1'b0, "R9 read clears ready and irq", {v[7], irq}, 0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    peek(2'd0, v); check(v == 16'd0, "R1 config reset", v, 0);
    peek(2'd2, v); check(v == 16'd0, "R1 hwcfg reset", v, 0);
    peek(2'd1, v); check(v == 16'd0, "R1 result reset", v, 0);
    check(irq == 1'b0 && chargeOut == 4'd0, "R1 outputs reset", {irq, chargeOut}, 0);

    // R11 hwcfg readback, R7 ready not writable
    regWrite(2'd2, 8'hFF);
    peek(2'd2, v); check(v == 16'h000F, "R11 hwcfg upper zero", v, 16'h000F);
    regWrite(2'd0, 8'hBF);
    peek(2'd0, v); check(v == 16'h003F, "R7 ready read-only", v, 16'h003F);
    check(chargeOut == 4'd0, "R2 config write alone starts nothing", chargeOut, 0);

    // directed: each prescale code, select mapping
    measure(4'hF, 5, 17, 0, 40, 2'b00, 1'b1);
    measure(4'hF, 7, 8, 31, 2, 2'b10, 1'b0);
    measure(4'b0101, 45, 300, 99, 7, 2'b01, 1'b1);
    measure(4'b1010, 0, 450, 900, 401, 2'b11, 1'b1);
    // R6 saturation
    measure(4'b0001, 70000, 0, 0, 0, 2'b00, 1'b0);

    // random mix
    for (int t = 0; t < 16; t++) begin
      measure(4'($urandom_range(0, 15)), int'($urandom_range(0, 300)),
              int'($urandom_range(0, 300)), int'($urandom_range(0, 300)),
              int'($urandom_range(0, 300)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end

    // R10 continuous restart
    regWrite(2'd2, 8'h01);
    regWrite(2'd0, 8'h4F);
    @(negedge clk) compIn = 4'hF;
    regWrite(2'd1, 8'h00);
    repeat (3) @(negedge clk);
    peek(2'd0, v);
    check(v[7] == 1'b1 && irq == 1'b1, "R10 first continuous result", {v[7], irq}, 3);
    clearRead();
    peek(2'd0, v);
    check(v[7] == 1'b0, "R9 clear in continuous mode", v[7], 0);
    repeat (GAP + 6) @(negedge clk);
    peek(2'd0, v);
    check(v[7] == 1'b1 && irq == 1'b1, "R10 automatic re-measure", {v[7], irq}, 3);
    regWrite(2'd0, 8'h0F);
    clearRead();
    repeat (GAP + 6) @(negedge clk);
    peek(2'd0, v);
    check(v[7] == 1'b0, "R10 no restart without continuous bit", v[7], 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end
endmodule